// File: doc/BRIEF.md
# Address-Pattern Bank Switch Controller

This block sits beside a byte-wide memory that a host can only address through a 32 KB window. It listens to the host's read cycles, each presented as a one-cycle strobe along with four dedicated address bits. When those bits trace out a fixed sixteen-step key, it switches the window to one of up to sixteen 32 KB banks, or turns every bank off. Nothing else on the address bus matters, and no register is ever written. The bank number rides in the low bit of the last five steps of the key.

Entry has to be framed first. A read with all four watched bits high arms the matcher at step zero. Steps 0 to 10 must then match the stored key word exactly. Steps 11 to 15 must match on their upper three bits, while their lowest bit feeds a 5-bit bank code. The selection changes only when the sixteenth step matches. Until then, the selected bank stays put whatever the bus does. A power-good reset deselects everything, so several such blocks can share one bus after power-up without contention.

The outputs are a registered one-hot select, the encoded bank number and a "bank active" flag. The flag is meant to gate the chip enable of the storage.

Top module: `bank_unlock_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are `bank_onehot` = 0, `bank_active` = 0 and `bank_idx` = 0, and the matcher is disarmed.
- R2: Key steps are accepted only after an arming read whose `pat_addr` is 4'b1111; a correct sixteen-step key sent without that arming read leaves the selection unchanged.
- R3: In steps 0 to 10, `pat_addr` must equal key word `KEY_WORDS[4*s+3:4*s]` on all four bits. A mismatch disarms the matcher and leaves the selection unchanged.
- R4: In steps 11 to 15, only `pat_addr[3:1]` is compared with the key word. `pat_addr[0]` is shifted into a 5-bit code, step 11 first and ending up as the most significant bit. A mismatch of the compared bits disarms the matcher and leaves the selection unchanged.
- R5: The outputs change at the clock edge that samples the sixteenth matching read, and not at any earlier edge of the sequence.
- R6: The received code is XORed with `CODE_MASK` to give a value d. If d[4] = 1, all banks are turned off. Otherwise bank d[3:0] is requested.
- R7: A requested bank number at or above `NUM_BANKS` selects no bank: `bank_onehot` = 0, `bank_active` = 0, `bank_idx` = 0.
- R8: At most one bit of `bank_onehot` is set. `bank_active` is high exactly when one bit is set, and then `bank_idx` gives that bit's position.
- R9: A selection persists across any number of further reads until another sequence completes.
- R10: A cycle with `wr_strobe` high is not a read: it neither advances nor disarms the matcher, even when `rd_strobe` is also high or `pat_addr` is 4'b1111.
- R11: Cycles with no strobe leave the matcher and the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-good reset |
| rd_strobe | input | 1 | One-cycle read event |
| wr_strobe | input | 1 | One-cycle write event (suppresses matching) |
| pat_addr | input | 4 | Watched address bits of the current cycle |
| bank_onehot | output | NUM_BANKS | Registered one-hot bank select |
| bank_idx | output | 4 | Encoded bank number, 0 when none is active |
| bank_active | output | 1 | High when a bank is selected; gates storage enable |

## Verification
A corrupted step counter or arming flag cannot be seen at the ports until a sequence should complete, at the sixteenth read after arming. There it appears as a missed switch or as a switch one read early. A bad code shift register or decoder shows up at that same edge as the wrong one-hot bit or a wrong encoded number. Sweeping every 5-bit code therefore exposes each code bit position. Corrupting each of the sixteen steps in turn exposes a compare that is too loose at any position, because the output would then switch when it must hold.

// File: rtl/bank_unlock_pkg.sv
package bank_unlock_pkg;
  localparam int unsigned STEPS    = 16;
  localparam int unsigned WORD_W   = 4;
  localparam int unsigned TAIL_LEN = 5;
  localparam int unsigned CODE_W   = TAIL_LEN;
  localparam int unsigned BANK_W   = CODE_W - 1;
  localparam int unsigned STEP_W   = $clog2(STEPS);
  localparam int unsigned TAIL_FIRST = STEPS - TAIL_LEN;

  typedef logic [STEP_W-1:0] step_t;
  typedef logic [CODE_W-1:0] code_t;
  typedef logic [BANK_W-1:0] bank_t;
endpackage

// File: rtl/bu_step_matcher.sv
module bu_step_matcher
  import bank_unlock_pkg::*;
#(
  parameter logic [STEPS*WORD_W-1:0] KEY_WORDS = 64'hA6C4_2817_E096_C3A5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_strobe,
  input  logic              wr_strobe,
  input  logic [WORD_W-1:0] pat_addr,
  output logic              seq_done,
  output code_t             seq_code
);
  localparam step_t LAST_STEP = step_t'(STEPS - 1);
  localparam step_t TAIL_STEP = step_t'(TAIL_FIRST);
  localparam logic [WORD_W-1:0] ARM_WORD = '1;

  step_t                   step_q;
  logic                    armed_q;
  logic [CODE_W-2:0]       code_q;
  logic [WORD_W-1:0]       expect_w;
  logic [WORD_W-1:0]       cmp_mask;
  logic                    in_tail;
  logic                    hit;
  logic                    rd_ev;

  assign rd_ev    = rd_strobe && !wr_strobe;
  assign expect_w = KEY_WORDS[{step_q, 2'b00} +: WORD_W];
  assign in_tail  = (step_q >= TAIL_STEP);
  assign cmp_mask = in_tail ? {{(WORD_W-1){1'b1}}, 1'b0} : '1;
  assign hit      = armed_q && (((pat_addr ^ expect_w) & cmp_mask) == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q  <= '0;
      armed_q <= 1'b0;
      code_q  <= '0;
    end else if (rd_ev) begin
      if (hit) begin
        if (step_q == LAST_STEP) begin
          step_q  <= '0;
          armed_q <= 1'b0;
        end else begin
          step_q <= step_q + step_t'(1);
        end
        if (in_tail) begin
          code_q <= {code_q[CODE_W-3:0], pat_addr[0]};
        end
      end else if (pat_addr == ARM_WORD) begin
        step_q  <= '0;
        armed_q <= 1'b1;
      end else begin
        step_q  <= '0;
        armed_q <= 1'b0;
      end
    end
  end

  assign seq_done = rd_ev && hit && (step_q == LAST_STEP);
  assign seq_code = {code_q, pat_addr[0]};
endmodule

// File: rtl/bu_bank_decoder.sv
module bu_bank_decoder
  import bank_unlock_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 12,
  parameter code_t       CODE_MASK = 5'b10110
) (
  input  code_t                code_in,
  output logic [NUM_BANKS-1:0] onehot,
  output bank_t                idx,
  output logic                 valid
);
  code_t d;
  logic  off;

  assign d   = code_in ^ CODE_MASK;
  assign off = d[CODE_W-1];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign onehot[b] = !off && (d[BANK_W-1:0] == bank_t'(b));
  end

  assign valid = |onehot;
  assign idx   = valid ? d[BANK_W-1:0] : '0;
endmodule

// File: rtl/bu_sel_reg.sv
module bu_sel_reg
  import bank_unlock_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic [NUM_BANKS-1:0] onehot_in,
  input  bank_t                idx_in,
  input  logic                 valid_in,
  output logic [NUM_BANKS-1:0] onehot_q,
  output bank_t                idx_q,
  output logic                 active_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      onehot_q <= '0;
      idx_q    <= '0;
      active_q <= 1'b0;
    end else if (load) begin
      onehot_q <= onehot_in;
      idx_q    <= idx_in;
      active_q <= valid_in;
    end
  end
endmodule

// File: rtl/bank_unlock_ctrl.sv
module bank_unlock_ctrl
  import bank_unlock_pkg::*;
#(
  parameter int unsigned               NUM_BANKS = 12,
  parameter logic [STEPS*WORD_W-1:0]   KEY_WORDS = 64'hA6C4_2817_E096_C3A5,
  parameter logic [CODE_W-1:0]         CODE_MASK = 5'b10110
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_strobe,
  input  logic                 wr_strobe,
  input  logic [WORD_W-1:0]    pat_addr,
  output logic [NUM_BANKS-1:0] bank_onehot,
  output logic [BANK_W-1:0]    bank_idx,
  output logic                 bank_active
);
  logic                 done;
  code_t                code;
  logic [NUM_BANKS-1:0] dec_onehot;
  bank_t                dec_idx;
  logic                 dec_valid;

  bu_step_matcher #(.KEY_WORDS(KEY_WORDS)) u_match (
    .clk(clk), .rst(rst), .rd_strobe(rd_strobe), .wr_strobe(wr_strobe),
    .pat_addr(pat_addr), .seq_done(done), .seq_code(code)
  );

  bu_bank_decoder #(.NUM_BANKS(NUM_BANKS), .CODE_MASK(CODE_MASK)) u_dec (
    .code_in(code), .onehot(dec_onehot), .idx(dec_idx), .valid(dec_valid)
  );

  bu_sel_reg #(.NUM_BANKS(NUM_BANKS)) u_sel (
    .clk(clk), .rst(rst), .load(done), .onehot_in(dec_onehot),
    .idx_in(dec_idx), .valid_in(dec_valid), .onehot_q(bank_onehot),
    .idx_q(bank_idx), .active_q(bank_active)
  );
endmodule

// File: rtl/bu_checker.sv
module bu_checker #(
  parameter int unsigned NUM_BANKS = 12
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 rd_strobe,
  input logic                 wr_strobe,
  input logic [NUM_BANKS-1:0] bank_onehot,
  input logic [3:0]           bank_idx,
  input logic                 bank_active
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (bank_onehot == '0 && !bank_active && bank_idx == '0));

  assert_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bank_onehot));

  assert_active_match_R8: assert property (@(posedge clk) disable iff (rst)
    bank_active == ($countones(bank_onehot) == 1));

  assert_idx_range_R7: assert property (@(posedge clk) disable iff (rst)
    bank_active |-> (32'(bank_idx) < NUM_BANKS));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !rd_strobe |=> $stable(bank_onehot) && $stable(bank_idx));

  assert_write_hold_R10: assert property (@(posedge clk) disable iff (rst)
    wr_strobe |=> $stable(bank_onehot) && $stable(bank_active));
endmodule

bind bank_unlock_ctrl bu_checker #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk(clk), .rst(rst), .rd_strobe(rd_strobe), .wr_strobe(wr_strobe),
  .bank_onehot(bank_onehot), .bank_idx(bank_idx), .bank_active(bank_active)
);

// File: tb/sim_bank_unlock_ctrl.sv
module sim_bank_unlock_ctrl;
  localparam int          NB   = 12;
  localparam logic [63:0] KEY  = 64'hA6C4_2817_E096_C3A5;
  localparam logic [4:0]  MASK = 5'b10110;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rd_strobe = 1'b0;
  logic wr_strobe = 1'b0;
  logic [3:0] pat_addr = 4'h0;
  logic [NB-1:0] bank_onehot;
  logic [3:0] bank_idx;
  logic bank_active;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  bank_unlock_ctrl #(.NUM_BANKS(NB), .KEY_WORDS(KEY), .CODE_MASK(MASK)) u0 (
    .clk(clk), .rst(rst), .rd_strobe(rd_strobe), .wr_strobe(wr_strobe),
    .pat_addr(pat_addr), .bank_onehot(bank_onehot), .bank_idx(bank_idx),
    .bank_active(bank_active)
  );

  logic [NB-1:0] exp_oh;
  logic [3:0]    exp_idx;
  logic          exp_act;

  task automatic expect_code(input logic [4:0] raw);
    logic [4:0] d;
    d = raw ^ MASK;
    if (!d[4] && int'(d[3:0]) < NB) begin
      exp_oh = NB'(1) << d[3:0]; exp_idx = d[3:0]; exp_act = 1'b1;
    end else begin
      exp_oh = '0; exp_idx = 4'h0; exp_act = 1'b0;
    end
  endtask

  task automatic check(input string req);
    total++;
    if (bank_onehot !== exp_oh || bank_idx !== exp_idx || bank_active !== exp_act) begin
      bad++;
      $display("FAIL %s: got oh=%h idx=%0d act=%b expected oh=%h idx=%0d act=%b",
               req, bank_onehot, bank_idx, bank_active, exp_oh, exp_idx, exp_act);
    end
  endtask

  task automatic cyc(input logic r, input logic w, input logic [3:0] a);
    @(negedge clk);
    rd_strobe = r; wr_strobe = w; pat_addr = a;
    @(negedge clk);
    rd_strobe = 1'b0; wr_strobe = 1'b0;
  endtask

  function automatic logic [3:0] step_word(input int s, input logic [4:0] raw);
    logic [3:0] w;
    w = KEY[4*s +: 4];
    if (s >= 11) w[0] = raw[15 - s];
    return w;
  endfunction

  // sync read then steps 0..14; caller sends step 15
  task automatic send_head(input logic [4:0] raw);
    cyc(1, 0, 4'hF);
    for (int s = 0; s < 15; s++) cyc(1, 0, step_word(s, raw));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [3:0] w;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    exp_oh = '0; exp_idx = 0; exp_act = 0;
    check("R1 reset state");

    // R5 R6 R7 R8: sweep every code
    for (int c = 0; c < 32; c++) begin
      logic [NB-1:0] prev_oh; logic [3:0] prev_idx; logic prev_act;
      prev_oh = exp_oh; prev_idx = exp_idx; prev_act = exp_act;
      send_head(5'(c));
      check("R5 no switch before last step");
      cyc(1, 0, step_word(15, 5'(c)));
      expect_code(5'(c));
      check("R6 R7 R8 code sweep");
      cyc(0, 0, 4'h0);
      check("R11 idle hold");
      if (c == 31) begin exp_oh = prev_oh; exp_idx = prev_idx; exp_act = prev_act; end
    end

    // select bank 3, then corrupt each step with a bank-5 tail
    send_head(5'd3 ^ MASK); cyc(1, 0, step_word(15, 5'd3 ^ MASK));
    expect_code(5'd3 ^ MASK);
    check("R6 bank 3 selected");
    for (int s = 0; s < 16; s++) begin
      cyc(1, 0, 4'hF);
      for (int k = 0; k < 16; k++) begin
        w = step_word(k, 5'd5 ^ MASK);
        if (k == s) w[3] = ~w[3];
        cyc(1, 0, w);
      end
      check(s < 11 ? "R3 corrupted head step" : "R4 corrupted tail step");
    end
    check("R9 selection persists");

    // R2: full key without arming read
    for (int k = 0; k < 16; k++) cyc(1, 0, step_word(k, 5'd9 ^ MASK));
    check("R2 no arming read");

    // R10: writes inside a sequence are ignored
    cyc(1, 0, 4'hF);
    for (int k = 0; k < 16; k++) begin
      if (k == 8) begin
        cyc(0, 1, 4'h0); cyc(1, 1, 4'hF); cyc(0, 1, 4'hF);
        check("R10 write mid sequence holds output");
      end
      cyc(1, 0, step_word(k, 5'd7 ^ MASK));
    end
    expect_code(5'd7 ^ MASK);
    check("R10 writes ignored, bank 7 selected");

    // R11: idle gaps inside a sequence
    cyc(1, 0, 4'hF);
    for (int k = 0; k < 16; k++) begin
      cyc(0, 0, 4'h0);
      cyc(1, 0, step_word(k, 5'd1 ^ MASK));
    end
    expect_code(5'd1 ^ MASK);
    check("R11 idle gaps tolerated, bank 1");

    // R1: reset mid-entry deselects and disarms
    cyc(1, 0, 4'hF);
    for (int k = 0; k < 6; k++) cyc(1, 0, step_word(k, 5'd2 ^ MASK));
    @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
    exp_oh = '0; exp_idx = 0; exp_act = 0;
    check("R1 reset deselects");
    for (int k = 6; k < 16; k++) cyc(1, 0, step_word(k, 5'd2 ^ MASK));
    check("R1 reset disarms matcher");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule